// File: doc/BRIEF.md
# Vertical-Blanking Caption and Signalling Serializer

This block places sliced data bytes into chosen lines of the vertical blanking interval. A host loads byte registers for each line slot over a simple write port. The video timing generator gives the current line number, the field and a pulse at the start of each line. When a line that a slot is programmed for begins, the block waits for the next bit-slot strobe and then sends that slot's bytes one bit per strobe. The data goes out on a serial output with a valid flag. Waveform shaping and the run-in pattern belong to later stages.

There are two kinds of slot. Caption slots send 16 bits taken from a low byte and a high byte. Signalling slots send 14 data bits. In NTSC mode 6 check bits follow them; in PAL mode the check bits are dropped. Each slot has a write-status flag. It drops when the host commits a full set of new bytes and rises once that data has been sent. If the host loads nothing new, the same bytes are sent again on every later occurrence of the line. Writes that arrive while a slot is being sent are held back until its line has finished.

Top module: `vbi_line_serializer`

## Requirements
- R1: A caption slot sends exactly 16 bits. Bits 0 to 7 of the low byte (offset 0) come first, starting with bit 0. Bits 0 to 7 of the high byte (offset 1) follow. Bit 7 of each byte (the parity position) is sent unchanged.
- R2: In NTSC mode (control bit 1 = 0), a signalling slot sends 20 bits. These are the low byte bits 0-7, then high byte bits 0-5, then check byte (offset 2) bits 0-5.
- R3: In PAL mode (control bit 1 = 1), a signalling slot sends only its first 14 bits, and the next strobe gives no valid bit. The check byte must still be written before a new set of bytes is taken.
- R4: After reset every status flag is 1 and the serial valid output is 0. A status flag drops to 0 within two clocks of the write that completes its slot's byte set. It rises to 1 in the same clock that the slot's last bit appears.
- R5: A slot that has not been rewritten sends its previous bytes again on its next line, and its status stays at 1.
- R6: A slot sends only when its enable bit is set and both its line (10 bits: offset 3 holds bits 7-0, offset 4 bits 1-0 hold bits 9-8) and its field (offset 4 bit 6) match. The enable bit is offset 4 bit 7. The line must also be marked by the line-start pulse. The first bit appears on the first strobe after that pulse, and each strobe moves out one bit.
- R7: Bytes written while a slot is armed or being sent do not change the word on that line. They take effect after the line has finished.
- R8: With host loading disabled (control register at address 0x38, bit 0 = 0), completed writes are held and not taken, so the status stays 1. Setting the bit later takes the held bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address: slot times 8 plus offset, or 0x38 for control |
| wr_data | input | 8 | Write data |
| line_num | input | 10 | Current line number from the timing generator |
| field_id | input | 1 | Current field |
| line_start | input | 1 | One-clock pulse at the start of each line |
| bit_strobe | input | 1 | One-clock pulse per serial bit slot |
| ser_data | output | 1 | Serial data bit |
| ser_valid | output | 1 | High for one clock when ser_data holds a bit |
| slot_status | output | 4 | Write-status flag per slot (1 = host may write) |

## Verification
A fault in the staging mask or the commit gate shows up on `slot_status`: the flag either fails to drop within two clocks of the completing write, or it drops while loading is disabled. A fault in the shift counter or the word selection shows up on the same line. The valid output then gives a wrong number of bits, or a wrong bit at a known position of the captured stream. A commit that breaks into a transmission corrupts the second half of that line's word. A skipped commit means the old word is sent again on the next occurrence of the line.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  localparam int BYTE_W    = 8;
  localparam int WSS_BITS  = 14;
  localparam int CHK_BITS  = 6;
  localparam int CAP_BITS  = 16;
  localparam int FRAME_MAX = WSS_BITS + CHK_BITS;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  // Assemble the transmit word; bit 0 leaves first.
  function automatic logic [FRAME_MAX-1:0] frame_word(input logic is_wss,
      input logic [BYTE_W-1:0] lo, input logic [BYTE_W-1:0] hi,
      input logic [BYTE_W-1:0] chk);
    if (is_wss) return {chk[CHK_BITS-1:0], hi[WSS_BITS-BYTE_W-1:0], lo};
    return {{(FRAME_MAX-CAP_BITS){1'b0}}, hi, lo};
  endfunction

  // Number of bits sent for a slot kind and standard.
  function automatic logic [CNT_W-1:0] frame_len(input logic is_wss, input logic pal);
    if (!is_wss) return CNT_W'(CAP_BITS);
    if (pal) return CNT_W'(WSS_BITS);
    return CNT_W'(FRAME_MAX);
  endfunction
endpackage

// File: rtl/vbi_slot_regs.sv
module vbi_slot_regs
  import vbi_pkg::*;
#(
  parameter int SLOT   = 0,
  parameter bit IS_WSS = 1'b0,
  parameter int ADDR_W = 6,
  parameter int LINE_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic                 host_en,
  input  logic                 busy_here,
  input  logic                 done_here,
  output logic                 status,
  output logic [FRAME_MAX-1:0] act_word,
  output logic [LINE_W-1:0]    cfg_line,
  output logic                 cfg_field,
  output logic                 cfg_en
);
  localparam logic [2:0] NEED = IS_WSS ? 3'b111 : 3'b011;

  logic [BYTE_W-1:0] stg_lo, stg_hi, stg_chk, act_lo, act_hi, act_chk;
  logic [2:0]        mask;
  logic              sel, commit;

  assign sel    = wr_en && (wr_addr[ADDR_W-1:3] == (ADDR_W-3)'(SLOT));
  assign commit = host_en && ((mask & NEED) == NEED) && !busy_here;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_lo <= '0; stg_hi <= '0; stg_chk <= '0;
      act_lo <= '0; act_hi <= '0; act_chk <= '0;
      mask <= '0; status <= 1'b1;
      cfg_line <= '0; cfg_field <= 1'b0; cfg_en <= 1'b0;
    end else begin
      if (commit) begin
        act_lo <= stg_lo; act_hi <= stg_hi; act_chk <= stg_chk;
        mask   <= '0;
        status <= 1'b0;
      end
      if (done_here) status <= 1'b1;
      if (sel) begin
        case (wr_addr[2:0])
          3'd0: begin stg_lo  <= wr_data; mask[0] <= 1'b1; end
          3'd1: begin stg_hi  <= wr_data; mask[1] <= 1'b1; end
          3'd2: begin stg_chk <= wr_data; mask[2] <= 1'b1; end
          3'd3: cfg_line[7:0] <= wr_data;
          3'd4: begin
            cfg_en    <= wr_data[7];
            cfg_field <= wr_data[6];
            cfg_line[LINE_W-1:8] <= wr_data[LINE_W-9:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign act_word = frame_word(IS_WSS, act_lo, act_hi, act_chk);

  AST_ACT_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_here |=> $stable(act_word)); // R7
  AST_STATUS_FALL_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) |-> $past(host_en)); // R8
endmodule

// File: rtl/vbi_bit_shifter.sv
module vbi_bit_shifter
  import vbi_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_strobe,
  input  logic                 arm_req,
  input  logic [SLOT_W-1:0]    arm_id,
  input  logic [FRAME_MAX-1:0] load_word,
  input  logic [CNT_W-1:0]     load_len,
  output logic                 busy,
  output logic [SLOT_W-1:0]    cur_slot,
  output logic                 done,
  output logic                 ser_data,
  output logic                 ser_valid
);
  logic                 armed, shifting;
  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     remain;

  assign busy = armed | shifting;
  assign done = shifting && bit_strobe && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; shifting <= 1'b0; cur_slot <= '0;
      shreg <= '0; remain <= '0; ser_data <= 1'b0; ser_valid <= 1'b0;
    end else begin
      ser_valid <= 1'b0;
      if (!busy && arm_req) begin
        armed    <= 1'b1;
        cur_slot <= arm_id;
      end else if (armed && bit_strobe) begin
        ser_data  <= load_word[0];
        ser_valid <= 1'b1;
        shreg     <= load_word >> 1;
        remain    <= load_len - CNT_W'(1);
        armed     <= 1'b0;
        shifting  <= 1'b1;
      end else if (shifting && bit_strobe) begin
        ser_data  <= shreg[0];
        ser_valid <= 1'b1;
        shreg     <= shreg >> 1;
        remain    <= remain - CNT_W'(1);
        if (done) shifting <= 1'b0;
      end
    end
  end

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> $past(bit_strobe)); // R6
  AST_LAST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shifting) |-> ser_valid); // R1
endmodule

// File: rtl/vbi_line_serializer.sv
module vbi_line_serializer
  import vbi_pkg::*;
#(
  parameter int NUM_CC  = 2,
  parameter int NUM_WSS = 2,
  parameter int ADDR_W  = 6,
  parameter int LINE_W  = 10,
  parameter int NUM_SLOTS = NUM_CC + NUM_WSS,
  parameter int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [LINE_W-1:0]    line_num,
  input  logic                 field_id,
  input  logic                 line_start,
  input  logic                 bit_strobe,
  output logic                 ser_data,
  output logic                 ser_valid,
  output logic [NUM_SLOTS-1:0] slot_status
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {3'b111, {(ADDR_W-3){1'b0}}};

  logic                 host_en, pal;
  logic                 busy, done, arm_req, wss_sel;
  logic [SLOT_W-1:0]    cur_slot, arm_id;
  logic [NUM_SLOTS-1:0] hit, busy_here, done_here;
  logic [FRAME_MAX-1:0] words [NUM_SLOTS];
  logic [FRAME_MAX-1:0] load_word;
  logic [CNT_W-1:0]     load_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_en <= 1'b0; pal <= 1'b0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      host_en <= wr_data[0]; pal <= wr_data[1];
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [LINE_W-1:0] c_line;
    logic              c_field, c_en;
    vbi_slot_regs #(.SLOT(i), .IS_WSS(i >= NUM_CC), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .host_en(host_en), .busy_here(busy_here[i]), .done_here(done_here[i]),
      .status(slot_status[i]), .act_word(words[i]),
      .cfg_line(c_line), .cfg_field(c_field), .cfg_en(c_en));
    assign hit[i]       = line_start && c_en && (c_line == line_num) && (c_field == field_id);
    assign busy_here[i] = busy && (cur_slot == SLOT_W'(i));
    assign done_here[i] = done && (cur_slot == SLOT_W'(i));

    AST_STATUS_RISE_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_status[i]) |-> ser_valid); // R4
  end

  // Lowest-numbered matching slot wins the line.
  always_comb begin
    arm_req = 1'b0;
    arm_id  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        arm_req = 1'b1;
        arm_id  = SLOT_W'(i);
      end
    end
  end

  assign wss_sel   = (32'(cur_slot) >= NUM_CC);
  assign load_word = words[cur_slot];
  assign load_len  = frame_len(wss_sel, pal);

  vbi_bit_shifter #(.SLOT_W(SLOT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .arm_req(arm_req), .arm_id(arm_id),
    .load_word(load_word), .load_len(load_len), .busy(busy), .cur_slot(cur_slot),
    .done(done), .ser_data(ser_data), .ser_valid(ser_valid));
endmodule

// File: tb/sim_vbi_line_serializer.sv
module sim_vbi_line_serializer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, field_id = 1'b0, line_start = 1'b0, bit_strobe = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [9:0] line_num = '0;
  logic       ser_data, ser_valid;
  logic [3:0] slot_status;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  vbi_line_serializer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_num(line_num), .field_id(field_id), .line_start(line_start),
    .bit_strobe(bit_strobe), .ser_data(ser_data), .ser_valid(ser_valid),
    .slot_status(slot_status));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cfg(input int slot, input logic [9:0] ln, input logic f);
    wr(6'(slot * 8 + 3), ln[7:0]);
    wr(6'(slot * 8 + 4), {1'b1, f, 4'b0, ln[9:8]});
  endtask

  task automatic begin_line(input logic [9:0] ln, input logic f);
    @(negedge clk); line_num = ln; field_id = f; line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  // Strobe n times and collect bits; nvalid counts the valid flags seen.
  task automatic grab(input int n, output logic [31:0] bits, output int nvalid);
    bits = '0; nvalid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_strobe = 1'b1;
      @(negedge clk); bit_strobe = 1'b0;
      if (ser_valid) begin bits[i] = ser_data; nvalid++; end
    end
  endtask

  function automatic logic [31:0] exp_cap(input logic [7:0] lo, input logic [7:0] hi);
    logic [31:0] e = '0;
    for (int k = 0; k < 16; k++) e[k] = (k < 8) ? lo[k] : hi[k-8];
    return e;
  endfunction

  function automatic logic [31:0] exp_wss(input logic [7:0] lo, input logic [7:0] hi,
                                          input logic [7:0] ck, input int n);
    logic [31:0] e = '0;
    for (int k = 0; k < n; k++)
      e[k] = (k < 8) ? lo[k] : (k < 14) ? hi[k-8] : ck[k-14];
    return e;
  endfunction

  logic [31:0] got;
  int nv;

  task automatic t_reset;
    check(slot_status == 4'hF, "R4 reset status", 32'(slot_status), 32'hF);
    check(ser_valid == 1'b0, "R4 reset valid", 32'(ser_valid), 0);
  endtask

  task automatic t_caption;
    wr(6'h38, 8'h01);
    cfg(0, 10'd21, 1'b0);
    wr(6'h00, 8'h95); wr(6'h01, 8'hC3);
    idle(2);
    check(slot_status[0] == 1'b0, "R4 status drop", 32'(slot_status[0]), 0);
    begin_line(10'd21, 1'b0);
    grab(15, got, nv);
    check(slot_status[0] == 1'b0, "R4 status low before last bit", 32'(slot_status[0]), 0);
    @(negedge clk); bit_strobe = 1'b1; @(negedge clk); bit_strobe = 1'b0;
    got[15] = ser_data; nv += int'(ser_valid);
    check(slot_status[0] == 1'b1, "R4 status rise on last bit", 32'(slot_status[0]), 1);
    check(got == exp_cap(8'h95, 8'hC3) && nv == 16, "R1 caption word", got, exp_cap(8'h95, 8'hC3));
    grab(1, got, nv);
    check(nv == 0, "R1 no 17th bit", 32'(nv), 0);
  endtask

  task automatic t_mismatch;
    begin_line(10'd21, 1'b1); grab(2, got, nv);
    check(nv == 0, "R6 wrong field", 32'(nv), 0);
    begin_line(10'd22, 1'b0); grab(2, got, nv);
    check(nv == 0, "R6 wrong line", 32'(nv), 0);
    @(negedge clk); line_num = 10'd21; field_id = 1'b0; grab(2, got, nv);
    check(nv == 0, "R6 no line start", 32'(nv), 0);
  endtask

  task automatic t_resend;
    begin_line(10'd21, 1'b0); grab(16, got, nv);
    check(got == exp_cap(8'h95, 8'hC3) && nv == 16, "R5 resend", got, exp_cap(8'h95, 8'hC3));
    check(slot_status[0] == 1'b1, "R5 status stays", 32'(slot_status[0]), 1);
  endtask

  task automatic t_wss_ntsc;
    cfg(2, 10'd23, 1'b0);
    wr(6'h10, 8'hA5); wr(6'h11, 8'h2D); wr(6'h12, 8'h3B);
    idle(2);
    begin_line(10'd23, 1'b0); grab(21, got, nv);
    check(got == exp_wss(8'hA5, 8'h2D, 8'h3B, 20) && nv == 20, "R2 ntsc word",
          got, exp_wss(8'hA5, 8'h2D, 8'h3B, 20));
  endtask

  task automatic t_pal;
    wr(6'h38, 8'h03);
    wr(6'h10, 8'h5A); wr(6'h11, 8'h13);
    idle(3);
    check(slot_status[2] == 1'b1, "R3 check byte required", 32'(slot_status[2]), 1);
    begin_line(10'd23, 1'b0); grab(15, got, nv);
    check(got == exp_wss(8'hA5, 8'h2D, 8'h00, 14) && nv == 14, "R3 pal 14 bits old",
          got, exp_wss(8'hA5, 8'h2D, 8'h00, 14));
    wr(6'h12, 8'h3F); idle(2);
    check(slot_status[2] == 1'b0, "R3 complete after check byte", 32'(slot_status[2]), 0);
    begin_line(10'd23, 1'b0); grab(15, got, nv);
    check(got == exp_wss(8'h5A, 8'h13, 8'h00, 14) && nv == 14, "R3 pal new word",
          got, exp_wss(8'h5A, 8'h13, 8'h00, 14));
    wr(6'h38, 8'h01);
  endtask

  task automatic t_staged;
    logic [31:0] lo_half, hi_half;
    begin_line(10'd21, 1'b0); grab(8, lo_half, nv);
    wr(6'h00, 8'h0F); wr(6'h01, 8'hF0);
    idle(2);
    check(slot_status[0] == 1'b1, "R7 held during line", 32'(slot_status[0]), 1);
    grab(8, hi_half, nv);
    got = lo_half | (hi_half << 8);
    check(got == exp_cap(8'h95, 8'hC3), "R7 word not torn", got, exp_cap(8'h95, 8'hC3));
    idle(2);
    check(slot_status[0] == 1'b0, "R7 commit after line", 32'(slot_status[0]), 0);
    begin_line(10'd21, 1'b0); grab(16, got, nv);
    check(got == exp_cap(8'h0F, 8'hF0), "R7 new word next line", got, exp_cap(8'h0F, 8'hF0));
  endtask

  task automatic t_host_off;
    wr(6'h38, 8'h00);
    cfg(1, 10'd21, 1'b1);
    wr(6'h08, 8'h77); wr(6'h09, 8'h88);
    idle(3);
    check(slot_status[1] == 1'b1, "R8 no commit when disabled", 32'(slot_status[1]), 1);
    begin_line(10'd21, 1'b1); grab(16, got, nv);
    check(got == 32'h0 && nv == 16, "R8 old bytes sent", got, 0);
    wr(6'h38, 8'h01); idle(1);
    check(slot_status[1] == 1'b0, "R8 commit on enable", 32'(slot_status[1]), 0);
    begin_line(10'd21, 1'b1); grab(16, got, nv);
    check(got == exp_cap(8'h77, 8'h88), "R8 held bytes sent", got, exp_cap(8'h77, 8'h88));
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_caption();
    t_mismatch();
    t_resend();
    t_wss_ntsc();
    t_pal();
    t_staged();
    t_host_off();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule